// File: doc/BRIEF.md
# Control Register Bank with Pin Overrides

This block is a byte-wide register bank that an external microcontroller reaches over a small parallel bus: an active-low chip select, a read strobe, a write strobe, a 5-bit address and an 8-bit bidirectional data bus. Nineteen bytes of configuration live at addresses 0 to 18. A static style input chooses how the two strobe pins are read. With the style input at 0 they are separate active-low read and write strobes. With it at 1, `bus_wr_n` is the single active-low access strobe and `bus_rd_n` gives the direction (1 read, 0 write). The bank also exposes its full contents on a flat image bus for the blocks it configures.

Several control outputs are the OR of one register bit and one dedicated pin. A control can therefore be forced by hardware, or left to software with the pin tied inactive; the register bit has to stay 0 while the pin is in charge. Two power-down requests exist. The clearing request comes from the `pdclr_n` pin or register 0 bit 5, and returns every register to zero. The keeping request comes from the `pdkeep_n` pin or register 0 bit 6, and leaves contents alone. Because the clearing bit clears itself, writing it acts as a one-shot software reset.

Two state machines carry the behaviour. The bus machine has states IDLE, WRITE and READ. Every state goes to WRITE while a write access is active, to READ while a read access is active, and to IDLE otherwise. A write commits only on the move into WRITE. The mode machine has states INIT, OPER and PDOWN. INIT goes to OPER on a start request. Any state goes to PDOWN on a power-down request. PDOWN goes to OPER when the request ends with a start request present, and to INIT when it ends without one. OPER stays in OPER until a power-down request. A start request is the `skip_init` pin or register 0 bit 7.

Top module: `ctl_regbank`

## Requirements
- R1: While `rst_n` is low, all 19 registers read as 0x00 and the mode outputs show INIT; the first clock after release still shows INIT.
- R2: With `bus_shared`=0, a write is active when `bus_cs_n`=0, `bus_wr_n`=0 and `bus_rd_n`=1. The byte on `bus_d` is stored at `bus_addr` on the first rising clock edge of the access only. Data changes later in the same access are not stored.
- R3: With `bus_shared`=1, `bus_wr_n`=0 together with `bus_cs_n`=0 marks an access. `bus_rd_n`=0 makes it a write, committed as in R2, and `bus_rd_n`=1 makes it a read.
- R4: `bus_d` is driven only while chip select and the read condition of the selected style are both active. It then carries the addressed register combinationally, in the same cycle.
- R5: Writes to addresses 19 to 31 change no register, and reads of those addresses return 0x00.
- R6: `ctl_pdclr` = NOT `pdclr_n` OR register 0 bit 5. While it is 1, the next clock edge clears all registers and blocks any write, and the mode goes to PDOWN.
- R7: `ctl_pdkeep` = NOT `pdkeep_n` OR register 0 bit 6. While it is 1, the mode goes to PDOWN at the next edge and register contents are unchanged.
- R8: Override outputs are combinational ORs. `ctl_ecmode` = `pin_ecmode` OR reg0 bit 0. `ctl_thru` = `pin_thru` OR reg1 bit 5. `ctl_xbyp` = `pin_xbyp` OR reg1 bit 7. `ctl_mlv[2:0]` = `pin_mlv` OR reg1 bits 2..0. `ctl_iosel[1:0]` = `pin_iosel` OR reg3 bits 6..5, with bit 6 going to `ctl_iosel[1]`.
- R9: INIT moves to OPER at the next edge when `skip_init` is 1 or reg0 bit 7 is 1. Leaving PDOWN goes to OPER under the same condition and to INIT otherwise. OPER stays in OPER until a power-down request.
- R10: Exactly one of `mode_init`, `mode_oper` and `mode_pdown` is 1 at all times after reset. Each is registered, so it changes one edge after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_shared | input | 1 | Strobe style: 0 separate strobes, 1 shared strobe plus direction |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_rd_n | input | 1 | Read strobe (style 0) or direction, 1 = read (style 1) |
| bus_wr_n | input | 1 | Write strobe (style 0) or access strobe (style 1) |
| bus_addr | input | 5 | Register address |
| bus_d | inout | 8 | Bidirectional data bus |
| pdclr_n | input | 1 | Active-low power-down request that clears registers |
| pdkeep_n | input | 1 | Active-low power-down request that keeps registers |
| skip_init | input | 1 | Start request: bypasses INIT |
| pin_ecmode | input | 1 | Pin half of the canceller-mode control |
| pin_thru | input | 1 | Pin half of the full-through control |
| pin_xbyp | input | 1 | Pin half of the transcoder-bypass control |
| pin_iosel | input | 2 | Pin half of the serial routing select |
| pin_mlv | input | 3 | Pin half of the mute level |
| ctl_pdclr | output | 1 | Effective clearing power-down |
| ctl_pdkeep | output | 1 | Effective keeping power-down |
| ctl_ecmode | output | 1 | Effective canceller mode |
| ctl_thru | output | 1 | Effective full-through |
| ctl_xbyp | output | 1 | Effective transcoder bypass |
| ctl_iosel | output | 2 | Effective routing select |
| ctl_mlv | output | 3 | Effective mute level |
| mode_init | output | 1 | Mode machine in INIT |
| mode_oper | output | 1 | Mode machine in OPER |
| mode_pdown | output | 1 | Mode machine in PDOWN |
| cfg_image | output | 152 | All registers; register i at bits i*8+7..i*8 |

## Verification
A corrupted register byte shows on `cfg_image` one edge after the faulty write or clear. The override outputs built from it change in the same cycle, and a read of that address returns the bad value at once. A bus machine stuck in WRITE drops the next write without any error. A bus machine that fails to enter WRITE stores every later data change, so a write whose data changes during the access is the stimulus that exposes it. A wrong mode state shows on the one-hot mode outputs one edge after its cause, and is most visible on the exit from PDOWN, where the start-request bit decides between INIT and OPER.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int unsigned CRF_DW   = 8;
    localparam int unsigned CRF_AW   = 5;
    localparam int unsigned CRF_NREG = 19;

    // register indices whose bits feed behaviour
    localparam int unsigned PWR_REG  = 0;
    localparam int unsigned PATH_REG = 1;
    localparam int unsigned IO_REG   = 3;

    // bit positions inside those registers
    localparam int unsigned PWR_ECM_BIT    = 0;
    localparam int unsigned PWR_CLR_BIT    = 5;
    localparam int unsigned PWR_KEEP_BIT   = 6;
    localparam int unsigned PWR_GO_BIT     = 7;
    localparam int unsigned PATH_MLV_LSB   = 0;
    localparam int unsigned PATH_MLV_W     = 3;
    localparam int unsigned PATH_THRU_BIT  = 5;
    localparam int unsigned PATH_XBYP_BIT  = 7;
    localparam int unsigned IO_SEL_LSB     = 5;
    localparam int unsigned IO_SEL_W       = 2;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } crf_bus_e;

    typedef enum logic [1:0] {
        MD_INIT  = 2'd0,
        MD_OPER  = 2'd1,
        MD_PDOWN = 2'd2
    } crf_mode_e;

endpackage

// File: rtl/crf_bus_fsm.sv
module crf_bus_fsm
    import crf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shared,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rd_act,
    output logic wr_commit
);

    crf_bus_e st_q;
    crf_bus_e st_d;
    logic     wr_act;
    logic     sel;
    logic     acc;

    // decode of the two strobe styles (R2, R3)
    always_comb begin
        sel = ~cs_n;
        acc = sel & ~wr_n;
        if (shared) begin
            rd_act = acc & rd_n;
            wr_act = acc & ~rd_n;
        end else begin
            rd_act = sel & ~rd_n;
            wr_act = sel & ~wr_n & rd_n;
        end
    end

    // next state
    always_comb begin
        st_d = BUS_IDLE;
        unique case (st_q)
            BUS_IDLE, BUS_WRITE, BUS_READ: begin
                if (wr_act)      st_d = BUS_WRITE;
                else if (rd_act) st_d = BUS_READ;
                else             st_d = BUS_IDLE;
            end
            default: st_d = BUS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    // outputs: one commit per write access
    always_comb begin
        wr_commit = 1'b0;
        unique case (st_q)
            BUS_IDLE:  wr_commit = wr_act;
            BUS_READ:  wr_commit = wr_act;
            BUS_WRITE: wr_commit = 1'b0;
            default:   wr_commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/crf_store.sv
module crf_store #(
    parameter int unsigned DW   = 8,
    parameter int unsigned AW   = 5,
    parameter int unsigned NREG = 19,
    localparam int unsigned IMG_W = NREG * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata,
    output logic [IMG_W-1:0] image
);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            regs[g] <= '0;
            else if (clr)                          regs[g] <= '0;
            else if (we && (waddr == AW'(g)))      regs[g] <= wdata;
        end
        assign image[g*DW +: DW] = regs[g];
    end

    // unmatched addresses fall through to zero (R5)
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (raddr == AW'(i)) rdata = regs[i];
        end
    end

endmodule

// File: rtl/crf_mode_fsm.sv
module crf_mode_fsm
    import crf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_any,
    input  logic go,
    output logic in_init,
    output logic in_oper,
    output logic in_pdown
);

    crf_mode_e st_q;
    crf_mode_e st_d;

    always_comb begin
        st_d = MD_INIT;
        unique case (st_q)
            MD_INIT: begin
                if (pd_any)  st_d = MD_PDOWN;
                else if (go) st_d = MD_OPER;
                else         st_d = MD_INIT;
            end
            MD_OPER: begin
                if (pd_any)  st_d = MD_PDOWN;
                else         st_d = MD_OPER;
            end
            MD_PDOWN: begin
                if (pd_any)  st_d = MD_PDOWN;
                else if (go) st_d = MD_OPER;
                else         st_d = MD_INIT;
            end
            default: st_d = MD_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MD_INIT;
        else        st_q <= st_d;
    end

    always_comb begin
        in_init  = 1'b0;
        in_oper  = 1'b0;
        in_pdown = 1'b0;
        unique case (st_q)
            MD_INIT:  in_init  = 1'b1;
            MD_OPER:  in_oper  = 1'b1;
            MD_PDOWN: in_pdown = 1'b1;
            default:  in_init  = 1'b1;
        endcase
    end

endmodule

// File: rtl/crf_override.sv
module crf_override #(
    parameter int unsigned MLV_W = 3,
    parameter int unsigned SEL_W = 2
) (
    input  logic             pdclr_n,
    input  logic             pdkeep_n,
    input  logic             r_clr,
    input  logic             r_keep,
    input  logic             r_ecm,
    input  logic             r_thru,
    input  logic             r_xbyp,
    input  logic [MLV_W-1:0] r_mlv,
    input  logic [SEL_W-1:0] r_sel,
    input  logic             p_ecm,
    input  logic             p_thru,
    input  logic             p_xbyp,
    input  logic [MLV_W-1:0] p_mlv,
    input  logic [SEL_W-1:0] p_sel,
    output logic             o_clr,
    output logic             o_keep,
    output logic             o_ecm,
    output logic             o_thru,
    output logic             o_xbyp,
    output logic [MLV_W-1:0] o_mlv,
    output logic [SEL_W-1:0] o_sel
);

    // power-down requests (R6, R7)
    assign o_clr  = ~pdclr_n  | r_clr;
    assign o_keep = ~pdkeep_n | r_keep;

    // single-bit overrides (R8)
    assign o_ecm  = p_ecm  | r_ecm;
    assign o_thru = p_thru | r_thru;
    assign o_xbyp = p_xbyp | r_xbyp;

    for (genvar m = 0; m < MLV_W; m++) begin : g_mlv
        assign o_mlv[m] = p_mlv[m] | r_mlv[m];
    end

    for (genvar s = 0; s < SEL_W; s++) begin : g_sel
        assign o_sel[s] = p_sel[s] | r_sel[s];
    end

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
    import crf_pkg::*;
#(
    parameter int unsigned DW   = CRF_DW,
    parameter int unsigned AW   = CRF_AW,
    parameter int unsigned NREG = CRF_NREG,
    localparam int unsigned IMG_W = NREG * DW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_shared,
    input  logic                  bus_cs_n,
    input  logic                  bus_rd_n,
    input  logic                  bus_wr_n,
    input  logic [AW-1:0]         bus_addr,
    inout  wire  [DW-1:0]         bus_d,
    input  logic                  pdclr_n,
    input  logic                  pdkeep_n,
    input  logic                  skip_init,
    input  logic                  pin_ecmode,
    input  logic                  pin_thru,
    input  logic                  pin_xbyp,
    input  logic [IO_SEL_W-1:0]   pin_iosel,
    input  logic [PATH_MLV_W-1:0] pin_mlv,
    output logic                  ctl_pdclr,
    output logic                  ctl_pdkeep,
    output logic                  ctl_ecmode,
    output logic                  ctl_thru,
    output logic                  ctl_xbyp,
    output logic [IO_SEL_W-1:0]   ctl_iosel,
    output logic [PATH_MLV_W-1:0] ctl_mlv,
    output logic                  mode_init,
    output logic                  mode_oper,
    output logic                  mode_pdown,
    output logic [IMG_W-1:0]      cfg_image
);

    localparam int unsigned PWR_BASE  = PWR_REG  * DW;
    localparam int unsigned PATH_BASE = PATH_REG * DW;
    localparam int unsigned IO_BASE   = IO_REG   * DW;

    logic          rd_act;
    logic          wr_commit;
    logic [DW-1:0] rd_byte;
    logic [DW-1:0] wr_byte;
    logic          go_req;

    assign wr_byte = bus_d;

    // tri-state drive only during an active read (R4)
    assign bus_d = rd_act ? rd_byte : {DW{1'bz}};

    crf_bus_fsm i_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .shared    (bus_shared),
        .cs_n      (bus_cs_n),
        .rd_n      (bus_rd_n),
        .wr_n      (bus_wr_n),
        .rd_act    (rd_act),
        .wr_commit (wr_commit)
    );

    crf_store #(
        .DW   (DW),
        .AW   (AW),
        .NREG (NREG)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl_pdclr),
        .we    (wr_commit),
        .waddr (bus_addr),
        .wdata (wr_byte),
        .raddr (bus_addr),
        .rdata (rd_byte),
        .image (cfg_image)
    );

    crf_override #(
        .MLV_W (PATH_MLV_W),
        .SEL_W (IO_SEL_W)
    ) i_ovr (
        .pdclr_n  (pdclr_n),
        .pdkeep_n (pdkeep_n),
        .r_clr    (cfg_image[PWR_BASE + PWR_CLR_BIT]),
        .r_keep   (cfg_image[PWR_BASE + PWR_KEEP_BIT]),
        .r_ecm    (cfg_image[PWR_BASE + PWR_ECM_BIT]),
        .r_thru   (cfg_image[PATH_BASE + PATH_THRU_BIT]),
        .r_xbyp   (cfg_image[PATH_BASE + PATH_XBYP_BIT]),
        .r_mlv    (cfg_image[PATH_BASE + PATH_MLV_LSB +: PATH_MLV_W]),
        .r_sel    (cfg_image[IO_BASE + IO_SEL_LSB +: IO_SEL_W]),
        .p_ecm    (pin_ecmode),
        .p_thru   (pin_thru),
        .p_xbyp   (pin_xbyp),
        .p_mlv    (pin_mlv),
        .p_sel    (pin_iosel),
        .o_clr    (ctl_pdclr),
        .o_keep   (ctl_pdkeep),
        .o_ecm    (ctl_ecmode),
        .o_thru   (ctl_thru),
        .o_xbyp   (ctl_xbyp),
        .o_mlv    (ctl_mlv),
        .o_sel    (ctl_iosel)
    );

    // start request: pin or software bit (R9)
    assign go_req = skip_init | cfg_image[PWR_BASE + PWR_GO_BIT];

    crf_mode_fsm i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_any   (ctl_pdclr | ctl_pdkeep),
        .go       (go_req),
        .in_init  (mode_init),
        .in_oper  (mode_oper),
        .in_pdown (mode_pdown)
    );

endmodule

// File: rtl/crf_chk.sv
module crf_chk #(
    parameter int unsigned DW   = 8,
    parameter int unsigned AW   = 5,
    parameter int unsigned NREG = 19
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_cs_n,
    input logic [AW-1:0]        bus_addr,
    input wire  [DW-1:0]        bus_d,
    input logic                 drive_en,
    input logic                 pdclr_n,
    input logic                 pdkeep_n,
    input logic                 skip_init,
    input logic                 pin_thru,
    input logic                 ctl_thru,
    input logic                 mode_init,
    input logic                 mode_oper,
    input logic                 mode_pdown,
    input logic [NREG*DW-1:0]   cfg_image
);

    localparam int unsigned CLR_IDX  = 5;
    localparam int unsigned KEEP_IDX = 6;

    // R4
    bus_drive_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> !bus_cs_n);

    // R5
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && (bus_addr >= AW'(NREG))) |-> (bus_d == '0));

    // R6
    clear_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pdclr_n |=> (cfg_image == '0));

    // R7
    keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdkeep_n && pdclr_n && !cfg_image[CLR_IDX] && bus_cs_n) |=> $stable(cfg_image));

    // R7
    keep_pdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pdkeep_n |=> mode_pdown);

    // R8
    thru_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_thru |-> ctl_thru);

    // R9
    skip_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_init && skip_init && pdclr_n && pdkeep_n
         && !cfg_image[CLR_IDX] && !cfg_image[KEEP_IDX]) |=> mode_oper);

    // R10
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({mode_init, mode_oper, mode_pdown}));

endmodule

bind ctl_regbank crf_chk #(
    .DW   (DW),
    .AW   (AW),
    .NREG (NREG)
) i_crf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs_n   (bus_cs_n),
    .bus_addr   (bus_addr),
    .bus_d      (bus_d),
    .drive_en   (rd_act),
    .pdclr_n    (pdclr_n),
    .pdkeep_n   (pdkeep_n),
    .skip_init  (skip_init),
    .pin_thru   (pin_thru),
    .ctl_thru   (ctl_thru),
    .mode_init  (mode_init),
    .mode_oper  (mode_oper),
    .mode_pdown (mode_pdown),
    .cfg_image  (cfg_image)
);

// File: tb/test_ctl_regbank.sv
module test_ctl_regbank;

    localparam int NR = 19;
    localparam int IW = NR * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_shared = 1'b0;
    logic bus_cs_n = 1'b1;
    logic bus_rd_n = 1'b1;
    logic bus_wr_n = 1'b1;
    logic [4:0] bus_addr = '0;
    logic pdclr_n = 1'b1;
    logic pdkeep_n = 1'b1;
    logic skip_init = 1'b0;
    logic pin_ecmode = 1'b0;
    logic pin_thru = 1'b0;
    logic pin_xbyp = 1'b0;
    logic [1:0] pin_iosel = '0;
    logic [2:0] pin_mlv = '0;
    logic tb_oe = 1'b0;
    logic [7:0] tb_dat = '0;
    wire  [7:0] bus_d;

    logic ctl_pdclr, ctl_pdkeep, ctl_ecmode, ctl_thru, ctl_xbyp;
    logic [1:0] ctl_iosel;
    logic [2:0] ctl_mlv;
    logic mode_init, mode_oper, mode_pdown;
    logic [IW-1:0] cfg_image;

    assign bus_d = tb_oe ? tb_dat : 8'bz;

    ctl_regbank i_ctl_regbank (
        .clk(clk), .rst_n(rst_n), .bus_shared(bus_shared), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_d(bus_d),
        .pdclr_n(pdclr_n), .pdkeep_n(pdkeep_n), .skip_init(skip_init),
        .pin_ecmode(pin_ecmode), .pin_thru(pin_thru), .pin_xbyp(pin_xbyp),
        .pin_iosel(pin_iosel), .pin_mlv(pin_mlv), .ctl_pdclr(ctl_pdclr),
        .ctl_pdkeep(ctl_pdkeep), .ctl_ecmode(ctl_ecmode), .ctl_thru(ctl_thru),
        .ctl_xbyp(ctl_xbyp), .ctl_iosel(ctl_iosel), .ctl_mlv(ctl_mlv),
        .mode_init(mode_init), .mode_oper(mode_oper), .mode_pdown(mode_pdown),
        .cfg_image(cfg_image)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit comparing = 1'b0;
    bit finished = 1'b0;

    // reference model state
    logic [7:0] m_regs [NR];
    int m_mode = 0;          // 0 init, 1 oper, 2 pdown
    bit m_busy = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [IW-1:0] act, input logic [IW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_wr_active();
        return !bus_cs_n && !bus_wr_n && (bus_shared ? !bus_rd_n : bus_rd_n);
    endfunction

    function automatic bit m_rd_active();
        return !bus_cs_n && (bus_shared ? (!bus_wr_n && bus_rd_n) : !bus_rd_n);
    endfunction

    function automatic logic [IW-1:0] m_image();
        logic [IW-1:0] v;
        for (int i = 0; i < NR; i++) v[i*8 +: 8] = m_regs[i];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) m_regs[i] = 8'h00;
            m_mode = 0;
            m_busy = 1'b0;
        end else begin
            bit clr;
            bit pd;
            bit go;
            bit wa;
            clr = !pdclr_n || m_regs[0][5];
            pd  = clr || !pdkeep_n || m_regs[0][6];
            go  = skip_init || m_regs[0][7];
            wa  = m_wr_active();
            if (pd)                      m_mode = 2;
            else if (m_mode != 1 && go)  m_mode = 1;
            else if (m_mode == 2)        m_mode = 0;
            if (clr) begin
                for (int i = 0; i < NR; i++) m_regs[i] = 8'h00;
            end else if (wa && !m_busy && int'(bus_addr) < NR) begin
                m_regs[bus_addr] = tb_dat;
            end
            m_busy = wa;
        end
    end

    // per-cycle comparison, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (comparing) begin
            logic [2:0] em;
            logic [11:0] ec;
            logic [7:0] er;
            chk(cfg_image === m_image(), "R2 R3 R5 R6 R7 register image",
                cfg_image, m_image());
            em = (m_mode == 0) ? 3'b100 : (m_mode == 1) ? 3'b010 : 3'b001;
            chk({mode_init, mode_oper, mode_pdown} === em, "R9 R10 mode",
                IW'({mode_init, mode_oper, mode_pdown}), IW'(em));
            ec = {!pdclr_n || m_regs[0][5], !pdkeep_n || m_regs[0][6],
                  pin_ecmode || m_regs[0][0], pin_thru || m_regs[1][5],
                  pin_xbyp || m_regs[1][7], pin_iosel | m_regs[3][6:5],
                  pin_mlv | m_regs[1][2:0]};
            chk({ctl_pdclr, ctl_pdkeep, ctl_ecmode, ctl_thru, ctl_xbyp, ctl_iosel, ctl_mlv} === ec,
                "R6 R7 R8 control outputs",
                IW'({ctl_pdclr, ctl_pdkeep, ctl_ecmode, ctl_thru, ctl_xbyp, ctl_iosel, ctl_mlv}),
                IW'(ec));
            if (m_rd_active()) begin
                er = (int'(bus_addr) < NR) ? m_regs[bus_addr] : 8'h00;
                chk(bus_d === er, "R4 R5 read data", IW'(bus_d), IW'(er));
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // two-cycle write access; data changes in the second cycle (R2)
    task automatic wr(input bit shr, input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_shared = shr;
        bus_addr = a;
        tb_dat = v;
        tb_oe = 1'b1;
        bus_cs_n = 1'b0;
        bus_wr_n = 1'b0;
        bus_rd_n = shr ? 1'b0 : 1'b1;
        @(negedge clk);
        tb_dat = ~v;
        @(negedge clk);
        bus_wr_n = 1'b1;
        bus_rd_n = 1'b1;
        bus_cs_n = 1'b1;
        tb_oe = 1'b0;
    endtask

    task automatic rd(input bit shr, input logic [4:0] a, output logic [7:0] got);
        @(negedge clk);
        bus_shared = shr;
        bus_addr = a;
        bus_cs_n = 1'b0;
        if (shr) bus_wr_n = 1'b0;
        else     bus_rd_n = 1'b0;
        @(posedge clk);
        #2;
        got = bus_d;
        @(negedge clk);
        bus_wr_n = 1'b1;
        bus_rd_n = 1'b1;
        bus_cs_n = 1'b1;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29 + 3) & 255);
    endfunction

    initial begin
        logic [7:0] got;
        logic [IW-1:0] snap;
        idle(3);
        // R1: state while reset is held
        chk(cfg_image === '0, "R1 reset image", cfg_image, '0);
        chk(mode_init === 1'b1, "R1 reset mode", IW'(mode_init), IW'(1));
        rst_n = 1'b1;
        comparing = 1'b1;
        idle(2);
        chk(mode_init === 1'b1, "R9 stays in INIT without start", IW'(mode_init), IW'(1));

        // R2 R3: fill registers with both strobe styles
        for (int i = 1; i < NR; i++) wr(i[0], 5'(i), pat(i));
        rd(1'b1, 5'd2, got);
        chk(got === pat(2), "R2 separate-strobe write read back", IW'(got), IW'(pat(2)));
        rd(1'b0, 5'd7, got);
        chk(got === pat(7), "R3 shared-strobe write read back", IW'(got), IW'(pat(7)));
        rd(1'b0, 5'd18, got);
        chk(got === pat(18), "R4 read of last register", IW'(got), IW'(pat(18)));

        // R5: out of range
        snap = cfg_image;
        wr(1'b0, 5'd19, 8'h5A);
        wr(1'b1, 5'd31, 8'hFF);
        chk(cfg_image === snap, "R5 out-of-range writes ignored", cfg_image, snap);
        rd(1'b0, 5'd19, got);
        chk(got === 8'h00, "R5 read of address 19", IW'(got), 0);
        rd(1'b1, 5'd25, got);
        chk(got === 8'h00, "R5 read of address 25", IW'(got), 0);

        // R9: software start
        wr(1'b0, 5'd0, 8'h80);
        chk(mode_oper === 1'b1, "R9 start bit enters OPER", IW'(mode_oper), IW'(1));

        // R8: overrides
        wr(1'b0, 5'd1, 8'h00);
        wr(1'b0, 5'd3, 8'h00);
        chk(ctl_thru === 1'b0, "R8 through off", IW'(ctl_thru), 0);
        pin_thru = 1'b1;
        pin_mlv = 3'b100;
        pin_iosel = 2'b01;
        idle(1);
        chk(ctl_thru === 1'b1, "R8 through forced by pin", IW'(ctl_thru), IW'(1));
        pin_thru = 1'b0;
        wr(1'b1, 5'd1, 8'hA3);
        wr(1'b0, 5'd3, 8'h40);
        chk({ctl_thru, ctl_xbyp, ctl_mlv} === 5'b11111, "R8 register plus pin mute level",
            IW'({ctl_thru, ctl_xbyp, ctl_mlv}), IW'(5'b11111));
        chk(ctl_iosel === 2'b11, "R8 routing select merge", IW'(ctl_iosel), IW'(2'b11));
        pin_ecmode = 1'b1;
        pin_xbyp = 1'b1;
        idle(2);
        pin_ecmode = 1'b0;
        pin_xbyp = 1'b0;
        pin_mlv = '0;
        pin_iosel = '0;

        // R7: keeping power-down by pin, with a write while down
        snap = cfg_image;
        @(negedge clk);
        pdkeep_n = 1'b0;
        idle(1);
        chk(mode_pdown === 1'b1, "R7 pin enters PDOWN", IW'(mode_pdown), IW'(1));
        chk(cfg_image === snap, "R7 contents kept", cfg_image, snap);
        wr(1'b0, 5'd9, 8'h3C);
        pdkeep_n = 1'b1;
        idle(1);
        chk(mode_oper === 1'b1, "R9 PDOWN exit to OPER with start bit", IW'(mode_oper), IW'(1));

        // R7: keeping power-down by register bit
        wr(1'b1, 5'd0, 8'hC0);
        chk(mode_pdown === 1'b1, "R7 register bit enters PDOWN", IW'(mode_pdown), IW'(1));
        wr(1'b0, 5'd0, 8'h80);
        idle(1);
        chk(mode_oper === 1'b1, "R9 back to OPER", IW'(mode_oper), IW'(1));
        rd(1'b0, 5'd9, got);
        chk(got === 8'h3C, "R7 write during keep power-down", IW'(got), IW'(8'h3C));

        // R6: self-clearing software power-down
        wr(1'b0, 5'd0, 8'hA0);
        chk(cfg_image === '0, "R6 register bit clears all", cfg_image, '0);
        chk(mode_pdown === 1'b1, "R6 clearing enters PDOWN", IW'(mode_pdown), IW'(1));
        idle(1);
        chk(mode_init === 1'b1, "R9 PDOWN exit to INIT after clear", IW'(mode_init), IW'(1));

        // R6: clearing pin blocks writes
        wr(1'b0, 5'd4, 8'h77);
        @(negedge clk);
        pdclr_n = 1'b0;
        idle(1);
        wr(1'b1, 5'd5, 8'h99);
        chk(cfg_image === '0, "R6 pin clears and blocks writes", cfg_image, '0);
        pdclr_n = 1'b1;
        idle(1);
        chk(mode_init === 1'b1, "R9 INIT after pin clear", IW'(mode_init), IW'(1));
        skip_init = 1'b1;
        idle(1);
        chk(mode_oper === 1'b1, "R9 skip pin enters OPER", IW'(mode_oper), IW'(1));
        idle(3);

        finished = 1'b1;
        comparing = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-path run hung actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule